// File: doc/BRIEF.md
# Floating-Point Special-Value Conditioner

This unit sits on both sides of a single-precision arithmetic datapath and enforces two optional fast modes. On the way in, it looks at the two operands of an operation. When flush-to-zero is enabled and the operation is arithmetic, it replaces subnormal operands with positive zero. When default-NaN mode is on, it replaces NaN operands with the canonical NaN. It reports when an operand was flushed. On the way out, it takes the unrounded result of the same operation as IEEE fields: sign, biased exponent and fraction. An exponent field of zero with a nonzero fraction marks a magnitude below the smallest normal. The unit also takes a flag saying that the datapath produced a NaN. From these it forms the final 32-bit word.

Output NaN selection works as follows. A NaN operand of an arithmetic operation wins over the computed result. Operand A takes precedence over operand B, and the chosen NaN is returned quieted. In default-NaN mode, and whenever the datapath generates a NaN of its own, the result is the canonical NaN instead. With flush-to-zero on, tiny results become positive zero and raise an underflow-flush flag. A signalling NaN operand raises an invalid-operation flag.

Sign-manipulation and copy operations (absolute value, negate, move) pass straight through. No flush, no NaN substitution and no flag applies to them. The operands and the result for a beat are presented together, and every output appears one clock after the beat, together with a valid strobe.

Top module: `fpc_cond`

## Requirements
- R1: With flush-to-zero on and an arithmetic operation (op_kind=0), an operand with exponent field 0 and nonzero fraction is presented as 32'h00000000, whatever its sign, and o_in_flush is 1. A flushed operand is thus an exact zero, so a flushed divisor reaches the datapath as zero.
- R2: With flush-to-zero off, subnormal operands pass unchanged and o_in_flush stays 0.
- R3: For a sign/copy operation (op_kind=1), both operands pass unchanged, including NaN fraction bits. The result word is {res_sign, res_exp, res_frac}, and all three flags stay 0, whatever the mode bits are.
- R4: For an arithmetic operation with no NaN involved, the result is {res_sign, res_exp, res_frac}, with one exception. When flush-to-zero is on and res_exp is 0 with a nonzero res_frac, the result is 32'h00000000 and o_uf_flush is 1.
- R5: In default-NaN mode, an arithmetic operation with a NaN operand (exponent 255, nonzero fraction) gives the result 32'h7FC00000. Each NaN operand is also presented as 32'h7FC00000.
- R6: With default-NaN mode off, an arithmetic operation with a NaN operand returns the first NaN, checking A before B, with fraction bit 22 forced to 1.
- R7: When res_nan_gen is 1 on an arithmetic operation with no NaN operand, the result is 32'h7FC00000 in either mode.
- R8: A signalling NaN operand (NaN with fraction bit 22 at 0) of an arithmetic operation sets o_invalid, in either mode.
- R9: Outputs appear exactly one clock after in_valid. o_valid follows in_valid with that delay, and the flags are 0 in any cycle where o_valid is 0.
- R10: Synchronous active-high reset clears o_valid, all flags and all data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat qualifier for all inputs |
| op_kind | input | 1 | 0 = arithmetic, 1 = sign/copy operation |
| ftz_en | input | 1 | Flush-to-zero mode enable |
| dn_en | input | 1 | Default-NaN mode enable |
| opa | input | 32 | Operand A, IEEE single |
| opb | input | 32 | Operand B, IEEE single |
| res_sign | input | 1 | Unrounded result sign |
| res_exp | input | 8 | Unrounded result biased exponent field |
| res_frac | input | 23 | Unrounded result fraction field |
| res_nan_gen | input | 1 | Datapath generated a NaN |
| o_valid | output | 1 | Outputs valid |
| o_opa | output | 32 | Conditioned operand A |
| o_opb | output | 32 | Conditioned operand B |
| o_in_flush | output | 1 | An operand was flushed to zero |
| o_result | output | 32 | Final result word |
| o_uf_flush | output | 1 | Result flushed to zero |
| o_invalid | output | 1 | Signalling NaN operand seen |

## Verification
The unit holds no state beyond its one output register, so any internal fault shows up on the very next valid beat. A wrong class decode or a wrong priority appears as a wrong word on o_opa, o_opb or o_result. A flag that does not match the word it belongs to (o_uf_flush with a nonzero result, o_in_flush with an unflushed operand) shows up in the same cycle. A broken valid path appears as flags or data one cycle early, one cycle late, or in beats where o_valid is low.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int N_OPS  = 2;

    typedef enum logic {
        OPK_ARITH    = 1'b0,
        OPK_SIGNCOPY = 1'b1
    } op_kind_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        logic is_sub;
        logic is_nan;
        logic is_snan;
    } fp_class_t;

    localparam fp_word_t CANON_NAN = '{sign: 1'b0, exp: '1, frac: {1'b1, {(FRAC_W-1){1'b0}}}};
    localparam fp_word_t POS_ZERO  = '0;

    function automatic logic fp_is_sub(fp_word_t w);
        return (w.exp == '0) && (w.frac != '0);
    endfunction

    function automatic logic fp_is_nan(fp_word_t w);
        return (&w.exp) && (w.frac != '0);
    endfunction

    function automatic logic fp_is_snan(fp_word_t w);
        return fp_is_nan(w) && !w.frac[FRAC_W-1];
    endfunction

    function automatic fp_class_t fp_classify(fp_word_t w);
        fp_class_t c;
        c.is_sub  = fp_is_sub(w);
        c.is_nan  = fp_is_nan(w);
        c.is_snan = fp_is_snan(w);
        return c;
    endfunction

    function automatic fp_word_t fp_quieten(fp_word_t w);
        fp_word_t q;
        q = w;
        q.frac[FRAC_W-1] = 1'b1;
        return q;
    endfunction

endpackage

// File: rtl/fpc_operand_cond.sv
module fpc_operand_cond
    import fpc_pkg::*;
(
    input  fp_word_t  raw,
    input  logic      arith,
    input  logic      ftz_en,
    input  logic      dn_en,
    output fp_word_t  cond,
    output logic      flushed,
    output fp_class_t cls
);
    always_comb begin
        cls     = fp_classify(raw);
        cond    = raw;
        flushed = 1'b0;
        if (arith) begin
            if (ftz_en && cls.is_sub) begin
                cond    = POS_ZERO;
                flushed = 1'b1;
            end else if (dn_en && cls.is_nan) begin
                cond = CANON_NAN;
            end
        end
    end
endmodule

// File: rtl/fpc_result_cond.sv
module fpc_result_cond
    import fpc_pkg::*;
(
    input  logic      arith,
    input  logic      ftz_en,
    input  logic      dn_en,
    input  fp_word_t  raw_a,
    input  fp_word_t  raw_b,
    input  fp_class_t cls_a,
    input  fp_class_t cls_b,
    input  fp_word_t  res_in,
    input  logic      nan_gen,
    output fp_word_t  res_out,
    output logic      uf_flush,
    output logic      invalid
);
    logic res_tiny;

    always_comb begin
        res_tiny = (res_in.exp == '0) && (res_in.frac != '0);
        res_out  = res_in;
        uf_flush = 1'b0;
        invalid  = 1'b0;
        if (arith) begin
            invalid = cls_a.is_snan || cls_b.is_snan;
            if (cls_a.is_nan) begin
                res_out = dn_en ? CANON_NAN : fp_quieten(raw_a);
            end else if (cls_b.is_nan) begin
                res_out = dn_en ? CANON_NAN : fp_quieten(raw_b);
            end else if (nan_gen) begin
                res_out = CANON_NAN;
            end else if (ftz_en && res_tiny) begin
                res_out  = POS_ZERO;
                uf_flush = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fpc_cond.sv
module fpc_cond
    import fpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              op_kind,
    input  logic              ftz_en,
    input  logic              dn_en,
    input  logic [31:0]       opa,
    input  logic [31:0]       opb,
    input  logic              res_sign,
    input  logic [EXP_W-1:0]  res_exp,
    input  logic [FRAC_W-1:0] res_frac,
    input  logic              res_nan_gen,
    output logic              o_valid,
    output logic [31:0]       o_opa,
    output logic [31:0]       o_opb,
    output logic              o_in_flush,
    output logic [31:0]       o_result,
    output logic              o_uf_flush,
    output logic              o_invalid
);
    op_kind_e  kind;
    logic      arith;
    fp_word_t  raw_op  [N_OPS];
    fp_word_t  cond_op [N_OPS];
    fp_class_t cls_op  [N_OPS];
    logic [N_OPS-1:0] flush_vec;
    fp_word_t  res_word;
    fp_word_t  res_final;
    logic      uf_c;
    logic      inv_c;

    assign kind      = op_kind_e'(op_kind);
    assign arith     = (kind == OPK_ARITH);
    assign raw_op[0] = fp_word_t'(opa);
    assign raw_op[1] = fp_word_t'(opb);
    assign res_word  = '{sign: res_sign, exp: res_exp, frac: res_frac};

    for (genvar i = 0; i < N_OPS; i++) begin : g_opnd
        fpc_operand_cond u_opnd (
            .raw     (raw_op[i]),
            .arith   (arith),
            .ftz_en  (ftz_en),
            .dn_en   (dn_en),
            .cond    (cond_op[i]),
            .flushed (flush_vec[i]),
            .cls     (cls_op[i])
        );
    end

    fpc_result_cond u_res (
        .arith    (arith),
        .ftz_en   (ftz_en),
        .dn_en    (dn_en),
        .raw_a    (raw_op[0]),
        .raw_b    (raw_op[1]),
        .cls_a    (cls_op[0]),
        .cls_b    (cls_op[1]),
        .res_in   (res_word),
        .nan_gen  (res_nan_gen),
        .res_out  (res_final),
        .uf_flush (uf_c),
        .invalid  (inv_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid    <= 1'b0;
            o_opa      <= '0;
            o_opb      <= '0;
            o_result   <= '0;
            o_in_flush <= 1'b0;
            o_uf_flush <= 1'b0;
            o_invalid  <= 1'b0;
        end else begin
            o_valid    <= in_valid;
            o_in_flush <= in_valid && (|flush_vec);
            o_uf_flush <= in_valid && uf_c;
            o_invalid  <= in_valid && inv_c;
            if (in_valid) begin
                o_opa    <= cond_op[0];
                o_opb    <= cond_op[1];
                o_result <= res_final;
            end
        end
    end

    assert_ftz_input_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_kind && ftz_en && fp_is_sub(opa)) |=> (o_opa == 32'h0 && o_in_flush));

    assert_ftz_off_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ftz_en) |=> !o_in_flush);

    assert_bypass_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_kind) |=> (o_opa == $past(opa) && o_opb == $past(opb)
                                   && !o_in_flush && !o_uf_flush && !o_invalid));

    assert_uf_zero_R4: assert property (@(posedge clk) disable iff (rst)
        o_uf_flush |-> (o_result == 32'h0));

    assert_default_nan_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_kind && dn_en && (fp_is_nan(opa) || fp_is_nan(opb)))
        |=> (o_result == 32'h7FC00000));

    assert_first_nan_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_kind && !dn_en && fp_is_nan(opa))
        |=> (o_result == {$past(opa[31:23]), 1'b1, $past(opa[21:0])}));

    assert_snan_invalid_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_kind && (fp_is_snan(opa) || fp_is_snan(opb))) |=> o_invalid);

    assert_valid_pipe_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> o_valid);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !o_valid |-> (!o_in_flush && !o_uf_flush && !o_invalid));

endmodule

// File: tb/fpc_cond_bench.sv
module fpc_cond_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, op_kind, ftz_en, dn_en;
    logic [31:0] opa, opb;
    logic        res_sign;
    logic [7:0]  res_exp;
    logic [22:0] res_frac;
    logic        res_nan_gen;
    logic        o_valid, o_in_flush, o_uf_flush, o_invalid;
    logic [31:0] o_opa, o_opb, o_result;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [31:0] DNAN = 32'h7FC00000;

    always #10 clk = ~clk;

    fpc_cond u_fpc_cond (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_kind(op_kind),
        .ftz_en(ftz_en), .dn_en(dn_en), .opa(opa), .opb(opb),
        .res_sign(res_sign), .res_exp(res_exp), .res_frac(res_frac),
        .res_nan_gen(res_nan_gen), .o_valid(o_valid), .o_opa(o_opa),
        .o_opb(o_opb), .o_in_flush(o_in_flush), .o_result(o_result),
        .o_uf_flush(o_uf_flush), .o_invalid(o_invalid)
    );

    function automatic bit m_sub(logic [31:0] x);
        return x[30:23] == 8'h00 && x[22:0] != 23'h0;
    endfunction
    function automatic bit m_nan(logic [31:0] x);
        return x[30:23] == 8'hFF && x[22:0] != 23'h0;
    endfunction
    function automatic bit m_snan(logic [31:0] x);
        return m_nan(x) && !x[22];
    endfunction
    function automatic logic [31:0] m_opnd(logic [31:0] x);
        if (op_kind) return x;
        if (ftz_en && m_sub(x)) return 32'h0;
        if (dn_en && m_nan(x)) return DNAN;
        return x;
    endfunction
    function automatic logic [31:0] m_result();
        logic [31:0] packed_res = {res_sign, res_exp, res_frac};
        if (op_kind) return packed_res;
        if (m_nan(opa)) return dn_en ? DNAN : (opa | 32'h00400000);
        if (m_nan(opb)) return dn_en ? DNAN : (opb | 32'h00400000);
        if (res_nan_gen) return DNAN;
        if (ftz_en && res_exp == 8'h0 && res_frac != 23'h0) return 32'h0;
        return packed_res;
    endfunction
    function automatic bit m_uf();
        return !op_kind && !m_nan(opa) && !m_nan(opb) && !res_nan_gen
               && ftz_en && res_exp == 8'h0 && res_frac != 23'h0;
    endfunction

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic drive(logic k, logic f, logic d, logic [31:0] a, logic [31:0] b,
                         logic [31:0] r, logic g);
        @(negedge clk);
        in_valid = 1'b1; op_kind = k; ftz_en = f; dn_en = d; opa = a; opb = b;
        {res_sign, res_exp, res_frac} = r; res_nan_gen = g;
    endtask

    task automatic verify(string tag);
        logic [31:0] e_a, e_b, e_r;
        logic e_fl, e_uf, e_inv;
        e_a   = m_opnd(opa);
        e_b   = m_opnd(opb);
        e_r   = m_result();
        e_fl  = !op_kind && ftz_en && (m_sub(opa) || m_sub(opb));
        e_uf  = m_uf();
        e_inv = !op_kind && (m_snan(opa) || m_snan(opb));
        @(negedge clk);
        check(tag, "valid", {31'b0, o_valid}, 32'd1);
        check(tag, "opa", o_opa, e_a);
        check(tag, "opb", o_opb, e_b);
        check(tag, "result", o_result, e_r);
        check(tag, "flags", {29'b0, o_in_flush, o_uf_flush, o_invalid}, {29'b0, e_fl, e_uf, e_inv});
    endtask

    task automatic vec(string tag, logic k, logic f, logic d, logic [31:0] a,
                       logic [31:0] b, logic [31:0] r, logic g);
        drive(k, f, d, a, b, r, g);
        verify(tag);
    endtask

    function automatic logic [31:0] rnd_opnd();
        logic s = 1'($urandom);
        logic [22:0] f = 23'($urandom);
        case ($urandom % 6)
            0: return {s, 8'(1 + $urandom % 254), f};
            1: return {s, 8'h00, f | 23'h1};
            2: return {s, 31'h0};
            3: return {s, 8'hFF, 23'h0};
            4: return {s, 8'hFF, 1'b1, f[21:0]};
            default: return {s, 8'hFF, 1'b0, f[21:0] | 22'h1};
        endcase
    endfunction

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 0; op_kind = 0; ftz_en = 0; dn_en = 0;
        opa = 0; opb = 0; res_sign = 0; res_exp = 0; res_frac = 0; res_nan_gen = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check("R10", "reset valid", {31'b0, o_valid}, 32'd0);
        check("R10", "reset result", o_result, 32'd0);
        check("R10", "reset flags", {29'b0, o_in_flush, o_uf_flush, o_invalid}, 32'd0);

        vec("R1", 0, 1, 0, 32'h80000001, 32'h3F800000, 32'h3F800000, 0);
        vec("R1", 0, 1, 0, 32'h3F800000, 32'h007FFFFF, 32'h7F800000, 0);
        vec("R2", 0, 0, 0, 32'h80000001, 32'h00400000, 32'h40000000, 0);
        vec("R3", 1, 1, 1, 32'h80000005, 32'h7F800123, 32'hFF800123, 0);
        vec("R3", 1, 1, 1, 32'h7F812345, 32'h00000000, 32'h00012345, 1);
        vec("R4", 0, 1, 0, 32'h3F800000, 32'h3F800000, 32'h80000010, 0);
        vec("R4", 0, 0, 0, 32'h3F800000, 32'h3F800000, 32'h80000010, 0);
        vec("R4", 0, 1, 0, 32'h3F800000, 32'h3F800000, 32'hC0A00000, 0);
        vec("R5", 0, 0, 1, 32'h7FC0BEEF, 32'h3F800000, 32'h0, 0);
        vec("R5", 0, 1, 1, 32'h3F800000, 32'hFF800001, 32'h0, 0);
        vec("R6", 0, 0, 0, 32'hFF800ABC, 32'h7FC00001, 32'h0, 0);
        vec("R6", 0, 0, 0, 32'h3F800000, 32'h7F812345, 32'h0, 0);
        vec("R7", 0, 0, 0, 32'h7F800000, 32'h00000000, 32'h12345678, 1);
        vec("R7", 0, 1, 1, 32'hFF800000, 32'h7F800000, 32'h12345678, 1);
        vec("R8", 0, 1, 1, 32'h3F800000, 32'h7F800001, 32'h0, 0);
        vec("R8", 0, 0, 0, 32'hFFA00000, 32'h3F800000, 32'h0, 0);

        // R9: idle beat after a flagged beat clears valid and flags
        drive(0, 1, 0, 32'h00000001, 32'h7F800001, 32'h00000001, 0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", "flags on valid beat", {29'b0, o_in_flush, o_uf_flush, o_invalid}, 32'd5);
        @(negedge clk);
        check("R9", "valid idle", {31'b0, o_valid}, 32'd0);
        check("R9", "flags idle", {29'b0, o_in_flush, o_uf_flush, o_invalid}, 32'd0);

        void'($urandom(32'd20240611));
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rr;
            rr = ($urandom % 3 == 0) ? {1'($urandom), 8'h00, 23'($urandom)} : $urandom;
            vec("RND", 1'($urandom % 4 == 0), 1'($urandom), 1'($urandom),
                rnd_opnd(), rnd_opnd(), rr, 1'($urandom % 5 == 0));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule